// File: doc/BRIEF.md
# Four-Channel DMA Register Bank

This block holds the programming state of a four-channel DMA engine behind an 8-bit I/O port. Software sets a channel's start address and transfer count through a 16-bit register pair, one byte at a time. A shared byte-pointer bit chooses whether a byte access reaches the low or the high half. Command ports give software control of the per-channel mask bits, the channel mode, the byte pointer and a global reset of the command state. The terminal-count status flags are read back through a port that clears them when it is read.

Transfers are modelled by a request input that names one channel. The block accepts the request only when that channel is unmasked and is not in cascade mode. Each accepted transfer shows the channel's current address, then moves the address up by one and the count down by one. The count register holds one less than the number of transfers still to go, so the channel reaches terminal count on the transfer that finds the count at zero. After that transfer the count reads 0xFFFF, and software gets a residue of zero by adding one with 16-bit wraparound. At terminal count an auto-init channel reloads its current registers from the base copies. Any other channel masks itself.

Top module: `dma_regbank`

## Requirements
- R1: After reset all four mask bits are 1, the byte pointer selects the low byte, the status flags are 0, and every address and count register reads 0x0000.
- R2: Port 2n holds channel n's address and port 2n+1 holds its count (n = 0..3). Each write or read to one of these ports moves the shared byte pointer, so the low byte is accessed first and the high byte second. A write loads both the base and the current copy.
- R3: A write of any value to port 0x0C returns the byte pointer to the low byte.
- R4: A write to port 0x0A selects the channel with data bits [1:0] and sets that channel's mask when bit 2 is 1 or clears it when bit 2 is 0. A write to 0x0E clears all masks. A write to 0x0F loads mask bit n from data bit n.
- R5: A write to port 0x0B selects the channel with data bits [1:0]. Data bit 4 enables auto-init. Bits [7:6] equal to 11 select cascade mode, in which transfer requests for that channel are not accepted.
- R6: A transfer request is accepted (xfer_ack=1) only when the named channel is unmasked and not in cascade mode. An accepted request presents the current address on xfer_addr, then increments the current address and decrements the current count. A refused request changes no register.
- R7: A count of N-1 gives exactly N transfers. The last transfer finds the count at 0x0000 and leaves it at 0xFFFF, so a count of 0x0000 gives one transfer.
- R8: At terminal count on a channel without auto-init, that channel's status flag and its mask bit are both set.
- R9: At terminal count on an auto-init channel, the current address and count reload from the base registers, the status flag is set and the mask bit is left unchanged.
- R10: A read of port 0x08 returns the four status flags in bits [3:0] with zeros above them, and clears the flags.
- R11: A write to port 0x0D sets all four mask bits, clears the status flags and returns the byte pointer to the low byte. The address and count registers keep their values.
- R12: Reads of the address and count ports return the current (running) value, not the base value. Reads of ports other than 0x00-0x08 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 4 | I/O port offset |
| io_wdata | input | 8 | Write data byte |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Read data, valid while io_rd is high |
| xfer_valid | input | 1 | Transfer request |
| xfer_chan | input | 2 | Channel named by the transfer request |
| xfer_ack | output | 1 | Request accepted this cycle |
| xfer_addr | output | 16 | Current address of the named channel |
| mask_o | output | 4 | Per-channel mask bits |

## Verification
The main path is tried with four programmed channels. Each has its own start address and count and a short run of transfers. The cases differ: one has no carry, one carries from the low to the high byte of the address, one wraps the address past 0xFFFF, and one runs the count down to exactly zero. Together they separate a correct byte order and per-channel storage from swapped halves, a missing carry or a crossed channel. Directed cases then take counts through terminal count with and without auto-init. They also cover masked and cascade-mode requests, byte-pointer resets in the middle of a pair, and a master clear while flags and masks are set.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;

    localparam int NUM_CH  = 4;
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int WORD_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int PORT_W  = 4;

    typedef enum logic [PORT_W-1:0] {
        PORT_STATUS  = 4'h8,
        PORT_SMASK   = 4'hA,
        PORT_MODE    = 4'hB,
        PORT_CLRPTR  = 4'hC,
        PORT_MCLR    = 4'hD,
        PORT_CLRMASK = 4'hE,
        PORT_ALLMASK = 4'hF
    } cmd_port_e;

    typedef struct packed {
        logic [NUM_CH-1:0] wr_addr;
        logic [NUM_CH-1:0] wr_cnt;
        logic              word_acc;
        logic              smask_wr;
        logic              mode_wr;
        logic              clrptr_wr;
        logic              mclr_wr;
        logic              clrmask_wr;
        logic              allmask_wr;
        logic              status_rd;
    } strobe_t;

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                    input logic hi);
        return hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/dma_rb_decode.sv
module dma_rb_decode
    import dma_rb_pkg::*;
(
    input  logic [PORT_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output strobe_t           stb
);
    logic is_word_port;
    logic [CH_W-1:0] sel_ch;

    assign is_word_port = ~io_addr[PORT_W-1];
    assign sel_ch       = io_addr[CH_W:1];

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            assign stb.wr_addr[g] = io_wr && is_word_port && (sel_ch == CH_W'(g)) && !io_addr[0];
            assign stb.wr_cnt[g]  = io_wr && is_word_port && (sel_ch == CH_W'(g)) &&  io_addr[0];
        end
    endgenerate

    assign stb.word_acc   = (io_wr || io_rd) && is_word_port;
    assign stb.smask_wr   = io_wr && (io_addr == PORT_SMASK);
    assign stb.mode_wr    = io_wr && (io_addr == PORT_MODE);
    assign stb.clrptr_wr  = io_wr && (io_addr == PORT_CLRPTR);
    assign stb.mclr_wr    = io_wr && (io_addr == PORT_MCLR);
    assign stb.clrmask_wr = io_wr && (io_addr == PORT_CLRMASK);
    assign stb.allmask_wr = io_wr && (io_addr == PORT_ALLMASK);
    assign stb.status_rd  = io_rd && (io_addr == PORT_STATUS);
endmodule

// File: rtl/dma_rb_chan.sv
module dma_rb_chan
    import dma_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic              hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              mode_wr,
    input  logic              mode_auto,
    input  logic              mode_casc,
    input  logic              step,
    output logic [WORD_W-1:0] cur_addr,
    output logic [WORD_W-1:0] cur_cnt,
    output logic              autoinit,
    output logic              cascade,
    output logic              at_tc
);
    logic [WORD_W-1:0] base_addr, base_cnt;

    assign at_tc = (cur_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            autoinit <= 1'b0;
            cascade  <= 1'b0;
        end else if (mode_wr) begin
            autoinit <= mode_auto;
            cascade  <= mode_casc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            cur_addr  <= '0;
        end else if (wr_addr) begin
            if (hi) begin
                base_addr[WORD_W-1:BYTE_W] <= wdata;
                cur_addr[WORD_W-1:BYTE_W]  <= wdata;
            end else begin
                base_addr[BYTE_W-1:0] <= wdata;
                cur_addr[BYTE_W-1:0]  <= wdata;
            end
        end else if (step) begin
            if (at_tc && autoinit) cur_addr <= base_addr;
            else                   cur_addr <= cur_addr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_cnt <= '0;
            cur_cnt  <= '0;
        end else if (wr_cnt) begin
            if (hi) begin
                base_cnt[WORD_W-1:BYTE_W] <= wdata;
                cur_cnt[WORD_W-1:BYTE_W]  <= wdata;
            end else begin
                base_cnt[BYTE_W-1:0] <= wdata;
                cur_cnt[BYTE_W-1:0]  <= wdata;
            end
        end else if (step) begin
            if (at_tc && autoinit) cur_cnt <= base_cnt;
            else                   cur_cnt <= cur_cnt - 1'b1;
        end
    end

    // R6
    step_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !at_tc && !wr_addr && !wr_cnt) |=>
        (cur_cnt == $past(cur_cnt) - 1'b1) && (cur_addr == $past(cur_addr) + 1'b1));

    // R7
    tc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && at_tc && !autoinit && !wr_cnt) |=> (cur_cnt == '1));

    // R9
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (step && at_tc && autoinit && !wr_cnt && !wr_addr) |=>
        (cur_cnt == $past(base_cnt)) && (cur_addr == $past(base_addr)));
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
    import dma_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] io_addr,
    input  logic [BYTE_W-1:0] io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [BYTE_W-1:0] io_rdata,
    input  logic              xfer_valid,
    input  logic [CH_W-1:0]   xfer_chan,
    output logic              xfer_ack,
    output logic [WORD_W-1:0] xfer_addr,
    output logic [NUM_CH-1:0] mask_o
);
    strobe_t stb;
    logic    ptr_hi;
    logic [NUM_CH-1:0] mask_q, tc_stat;
    logic [NUM_CH-1:0] step, at_tc, tc_hit, autoinit, cascade;
    logic [NUM_CH-1:0][WORD_W-1:0] cur_addr, cur_cnt;
    logic [CH_W-1:0] cmd_ch;

    assign cmd_ch = io_wdata[CH_W-1:0];

    dma_rb_decode u_dec (
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .stb     (stb)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
            assign step[g]   = xfer_valid && (xfer_chan == CH_W'(g)) && !mask_q[g] && !cascade[g];
            assign tc_hit[g] = step[g] && at_tc[g];

            dma_rb_chan u_ch (
                .clk       (clk),
                .rst       (rst),
                .wr_addr   (stb.wr_addr[g]),
                .wr_cnt    (stb.wr_cnt[g]),
                .hi        (ptr_hi),
                .wdata     (io_wdata),
                .mode_wr   (stb.mode_wr && (cmd_ch == CH_W'(g))),
                .mode_auto (io_wdata[4]),
                .mode_casc (io_wdata[7] && io_wdata[6]),
                .step      (step[g]),
                .cur_addr  (cur_addr[g]),
                .cur_cnt   (cur_cnt[g]),
                .autoinit  (autoinit[g]),
                .cascade   (cascade[g]),
                .at_tc     (at_tc[g])
            );

            // R8
            tc_mask_chk: assert property (@(posedge clk) disable iff (rst)
                (tc_hit[g] && !autoinit[g]) |=> mask_q[g]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)                               ptr_hi <= 1'b0;
        else if (stb.mclr_wr || stb.clrptr_wr) ptr_hi <= 1'b0;
        else if (stb.word_acc)                 ptr_hi <= ~ptr_hi;
    end

    always_ff @(posedge clk) begin
        if (rst || stb.mclr_wr) begin
            mask_q <= '1;
        end else begin
            logic [NUM_CH-1:0] nxt;
            nxt = mask_q;
            if (stb.smask_wr)   nxt[cmd_ch] = io_wdata[2];
            if (stb.clrmask_wr) nxt = '0;
            if (stb.allmask_wr) nxt = io_wdata[NUM_CH-1:0];
            mask_q <= nxt | (tc_hit & ~autoinit);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || stb.mclr_wr) tc_stat <= '0;
        else if (stb.status_rd) tc_stat <= tc_hit;
        else                    tc_stat <= tc_stat | tc_hit;
    end

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            if (!io_addr[PORT_W-1]) begin
                if (io_addr[0]) io_rdata = pick_byte(cur_cnt[io_addr[CH_W:1]], ptr_hi);
                else            io_rdata = pick_byte(cur_addr[io_addr[CH_W:1]], ptr_hi);
            end else if (io_addr == PORT_STATUS) begin
                io_rdata = BYTE_W'(tc_stat);
            end
        end
    end

    assign xfer_ack  = |step;
    assign xfer_addr = cur_addr[xfer_chan];
    assign mask_o    = mask_q;

    // R3
    clrptr_low_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == PORT_CLRPTR) |=> !ptr_hi);

    // R11
    mclr_state_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == PORT_MCLR) |=> (mask_q == '1) && (tc_stat == '0) && !ptr_hi);

    // R10
    status_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr == PORT_STATUS && !xfer_valid) |=> (tc_stat == '0));

    // R6
    ack_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_ack |-> $onehot0(step) && xfer_valid);
endmodule

// File: tb/sim_dma_regbank.sv
module sim_dma_regbank;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst = 1'b1;
    logic [3:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic        xfer_valid = 1'b0;
    logic [1:0]  xfer_chan = '0;
    logic        xfer_ack;
    logic [15:0] xfer_addr;
    logic [3:0]  mask_o;

    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_regbank u0 (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
        .xfer_valid(xfer_valid), .xfer_chan(xfer_chan),
        .xfer_ack(xfer_ack), .xfer_addr(xfer_addr), .mask_o(mask_o)
    );

    typedef struct packed {
        logic [1:0]  ch;
        logic [15:0] addr;
        logic [15:0] cnt;
        logic [7:0]  steps;
        logic [15:0] exp_addr;
        logic [15:0] exp_cnt;
    } vec_t;

    localparam vec_t TBL [4] = '{
        '{2'd0, 16'h1234, 16'h0010, 8'd3, 16'h1237, 16'h000D},
        '{2'd1, 16'h00FF, 16'h0100, 8'd2, 16'h0101, 16'h00FE},
        '{2'd2, 16'hFFFE, 16'h0005, 8'd4, 16'h0002, 16'h0001},
        '{2'd3, 16'hA5C3, 16'h0002, 8'd2, 16'hA5C5, 16'h0000}
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic wr16(input logic [3:0] a, input logic [15:0] v);
        wr(a, v[7:0]);
        wr(a, v[15:8]);
    endtask

    task automatic rd16(input logic [3:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(a, lo);
        rd(a, hi);
        v = {hi, lo};
    endtask

    task automatic xfer(input logic [1:0] ch, output logic ack, output logic [15:0] ad);
        @(negedge clk);
        xfer_chan = ch; xfer_valid = 1'b1;
        #1 ack = xfer_ack; ad = xfer_addr;
        @(negedge clk);
        xfer_valid = 1'b0;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] w;
        logic        ack;
        logic [15:0] ad;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1 check(mask_o == 4'hF, "R1 mask", mask_o, 4'hF);
        rd(4'h8, b);
        check(b == 8'h00, "R1 status", b, 0);
        rd16(4'h1, w);
        check(w == 16'h0000, "R1 count", w, 0);

        // R2 R6 R12 table of programmed channels
        for (int i = 0; i < 4; i++) begin
            wr(4'hC, 8'h00);
            wr16({1'b0, TBL[i].ch, 1'b0}, TBL[i].addr);
            wr16({1'b0, TBL[i].ch, 1'b1}, TBL[i].cnt);
            wr(4'hB, 8'h48 | {6'd0, TBL[i].ch});
            wr(4'hA, {6'd0, TBL[i].ch});
            for (int s = 0; s < int'(TBL[i].steps); s++) begin
                xfer(TBL[i].ch, ack, ad);
                check(ack == 1'b1, "R6 ack", ack, 1);
                check(ad == TBL[i].addr + 16'(s), "R6 xfer_addr", ad, TBL[i].addr + 16'(s));
            end
            rd16({1'b0, TBL[i].ch, 1'b0}, w);
            check(w == TBL[i].exp_addr, "R12 cur address", w, TBL[i].exp_addr);
            rd16({1'b0, TBL[i].ch, 1'b1}, w);
            check(w == TBL[i].exp_cnt, "R2 cur count", w, TBL[i].exp_cnt);
        end

        // R3 pointer reset in mid-pair
        wr(4'h0, 8'h77);
        wr(4'hC, 8'h5A);
        wr16(4'h0, 16'hBEEF);
        rd(4'h0, b);
        wr(4'hC, 8'hFF);
        rd16(4'h0, w);
        check(w == 16'hBEEF, "R3 clear pointer", w, 16'hBEEF);

        // R4 mask commands
        wr(4'hE, 8'h00);
        #1 check(mask_o == 4'h0, "R4 clear mask", mask_o, 0);
        wr(4'hA, 8'h05);
        #1 check(mask_o == 4'h2, "R4 single set", mask_o, 2);
        wr(4'hA, 8'h01);
        #1 check(mask_o == 4'h0, "R4 single clear", mask_o, 0);
        wr(4'hF, 8'h05);
        #1 check(mask_o == 4'h5, "R4 all mask", mask_o, 5);
        wr(4'hE, 8'h00);

        // R5 cascade channel refuses
        wr(4'hB, 8'hC2);
        rd16(4'h5, w);
        xfer(2'd2, ack, ad);
        check(ack == 1'b0, "R5 cascade ack", ack, 0);
        rd16(4'h5, ad);
        check(ad == w, "R5 cascade count kept", ad, w);
        wr(4'hB, 8'h48 | 8'h02);

        // R6 masked request ignored
        wr(4'hA, 8'h04);
        rd16(4'h1, w);
        xfer(2'd0, ack, ad);
        check(ack == 1'b0, "R6 masked ack", ack, 0);
        rd16(4'h1, ad);
        check(ad == w, "R6 masked count kept", ad, w);

        // R7 R8 single transfer from count 0
        rd(4'h8, b);
        wr16(4'h1, 16'h0000);
        wr(4'hA, 8'h00);
        xfer(2'd0, ack, ad);
        check(ack == 1'b1, "R7 one transfer", ack, 1);
        xfer(2'd0, ack, ad);
        check(ack == 1'b0, "R8 masked after tc", ack, 0);
        rd16(4'h1, w);
        check(w == 16'hFFFF, "R7 count after tc", w, 16'hFFFF);
        check(mask_o[0] == 1'b1, "R8 mask set", mask_o, 1);
        rd(4'h8, b);
        check(b == 8'h01, "R8 R10 status", b, 1);
        rd(4'h8, b);
        check(b == 8'h00, "R10 status cleared", b, 0);

        // R9 auto-init reload
        wr(4'hB, 8'h59);
        wr16(4'h2, 16'h2000);
        wr16(4'h3, 16'h0001);
        wr(4'hA, 8'h01);
        xfer(2'd1, ack, ad);
        check(ad == 16'h2000, "R9 first addr", ad, 16'h2000);
        xfer(2'd1, ack, ad);
        check(ad == 16'h2001, "R9 second addr", ad, 16'h2001);
        rd16(4'h3, w);
        check(w == 16'h0001, "R9 count reloaded", w, 1);
        rd16(4'h2, w);
        check(w == 16'h2000, "R9 addr reloaded", w, 16'h2000);
        check(mask_o[1] == 1'b0, "R9 mask kept", mask_o[1], 0);
        rd(4'h8, b);
        check(b == 8'h02, "R9 status", b, 2);

        // R11 master clear
        xfer(2'd1, ack, ad);
        xfer(2'd1, ack, ad);
        wr(4'hE, 8'h00);
        rd(4'h2, b);
        wr(4'hD, 8'h00);
        #1 check(mask_o == 4'hF, "R11 masks", mask_o, 4'hF);
        rd(4'h8, b);
        check(b == 8'h00, "R11 status", b, 0);
        rd16(4'h2, w);
        check(w == 16'h2000, "R11 pointer and addr kept", w, 16'h2000);

        // R12 unused port reads zero
        rd(4'h9, b);
        check(b == 8'h00, "R12 other port", b, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule